// File: doc/BRIEF.md
# Automatic Sector-Range CRC Sequencer

The block computes a CRC-16 over a contiguous run of 1024-byte memory sectors with no processor involvement. Software sets a start sector, a sector count and an enable bit through a small byte-wide register interface. It then writes to the CRC register, and the block walks every byte address in the chosen range. It reads each byte through a synchronous memory read port with one-cycle latency and folds the byte into a CRC engine.

While a scan runs, the block holds the processor with a stall output and clears its done indication. When the last byte has been absorbed, the stall drops and the done indication returns to 1. The 16-bit result can then be read from two register slots, and it is also visible on a dedicated output.

Register map on `reg_addr`:
- 0: mode register. Bit 7 is the enable bit, bit 6 reads as done and cannot be written, bits 5:0 hold the start sector.
- 1: span register. Bits 5:0 hold the sector count, and bits 7:6 always read 0.
- 2: CRC low byte. A write to this slot is the trigger.
- 3: CRC high byte.

Top module: `crc_range_scanner`

## Requirements
- R1: After reset, the mode register reads 0x40 and the span register reads 0x00. `scan_done` is 1 and `cpu_stall` is 0.
- R2: The span register keeps bits 5:0 of a write, and its bits 7:6 read 0 whatever was written. The mode register reads back the enable bit and the start sector as written. Its bit 6 reads 1 while idle.
- R3: A write to register slot 2 starts a scan only if the enable bit is 1. With the enable bit at 0, the same write leaves `cpu_stall` and `mem_rd_en` at 0 and leaves the CRC unchanged.
- R4: The first address issued is start×1024. Every following cycle of the issue phase presents the previous address plus 1 with `mem_rd_en` high.
- R5: The scan covers count+1 sectors. The last address issued is (start+count+1)×1024−1.
- R6: If start+count exceeds 63, the last address issued is 0xFFFF, and the address never wraps to 0.
- R7: `cpu_stall` rises in the cycle after the trigger write and stays high for (number of bytes scanned)+1 cycles. `scan_done` is the inverse of `cpu_stall`, and mode-register bit 6 follows `scan_done`.
- R8: The result is CRC-16 with polynomial 0x1021, preset to 0xFFFF at each trigger, and fed one byte per step MSB first. It appears on `crc_out` and in register slots 3:2 when `scan_done` returns to 1.
- R9: Register writes that arrive while `cpu_stall` is 1 change no register and start no new scan.
- R10: While no scan runs, `crc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register slot select for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid one cycle after the request |
| crc_out | output | 16 | Current CRC value |
| cpu_stall | output | 1 | Processor hold while a scan runs |
| scan_done | output | 1 | High when no scan is in progress |

## Verification
The trigger write is taken at a clock edge. From the next cycle, `cpu_stall` is high and the first address is on `mem_addr`. Addresses then advance one per cycle. The CRC lags the address by one cycle, so `scan_done` and the final CRC are due exactly one cycle after the last address. The bench drives and samples on the falling edge. It counts stalled cycles against the expected length, compares every issued address against a running expected address, and reads the CRC only once `cpu_stall` has fallen. Writes injected mid-scan are verified by reading the registers back after completion. The enable-off trigger is verified by watching the stall and CRC for several cycles.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;
  localparam int SECT_W_DEF    = 6;
  localparam int SECT_LOG2_DEF = 10;
  localparam logic [15:0] POLY_DEF   = 16'h1021;
  localparam logic [15:0] PRESET_DEF = 16'hFFFF;

  typedef enum logic [1:0] {
    SLOT_MODE   = 2'd0,
    SLOT_SPAN   = 2'd1,
    SLOT_CRC_LO = 2'd2,
    SLOT_CRC_HI = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/crc_scan_regs.sv
module crc_scan_regs
  import crc_scan_pkg::*;
#(
  parameter int SECT_W = SECT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic [15:0]       crc_val,
  output logic [7:0]        rdata,
  output logic [SECT_W-1:0] start_sect,
  output logic [SECT_W-1:0] span_sect,
  output logic              kick
);
  logic              en_q, en_d;
  logic [SECT_W-1:0] start_q, start_d;
  logic [SECT_W-1:0] span_q, span_d;
  logic              mode_ce, span_ce;
  logic [7:0]        mode_view, span_view;

  // writes only land while idle
  assign mode_ce = wr_en && !busy && (addr == SLOT_MODE);
  assign span_ce = wr_en && !busy && (addr == SLOT_SPAN);
  assign kick    = wr_en && !busy && (addr == SLOT_CRC_LO) && en_q;

  always_comb begin
    en_d    = en_q;
    start_d = start_q;
    span_d  = span_q;
    if (mode_ce) begin
      en_d    = wdata[7];
      start_d = wdata[SECT_W-1:0];
    end
    if (span_ce) begin
      span_d = wdata[SECT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= '0;
      span_q  <= '0;
    end else begin
      if (mode_ce) begin
        en_q    <= en_d;
        start_q <= start_d;
      end
      if (span_ce) begin
        span_q <= span_d;
      end
    end
  end

  always_comb begin
    mode_view               = '0;
    mode_view[7]            = en_q;
    mode_view[6]            = !busy;
    mode_view[SECT_W-1:0]   = start_q;
    span_view               = '0;
    span_view[SECT_W-1:0]   = span_q;
  end

  always_comb begin
    unique case (addr)
      SLOT_MODE:   rdata = mode_view;
      SLOT_SPAN:   rdata = span_view;
      SLOT_CRC_LO: rdata = crc_val[7:0];
      default:     rdata = crc_val[15:8];
    endcase
  end

  assign start_sect = start_q;
  assign span_sect  = span_q;
endmodule

// File: rtl/crc_scan_seq.sv
module crc_scan_seq
  import crc_scan_pkg::*;
#(
  parameter int SECT_W    = SECT_W_DEF,
  parameter int SECT_LOG2 = SECT_LOG2_DEF,
  localparam int ADDR_W   = SECT_W + SECT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [SECT_W-1:0] start_sect,
  input  logic [SECT_W-1:0] span_sect,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              take,
  output logic              busy
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              take_q;
  logic [SECT_W:0]   end_sect;
  logic [ADDR_W-1:0] first_addr, last_addr;

  // end sector may run past the top of the space: clamp rather than wrap
  assign end_sect   = {1'b0, start_sect} + {1'b0, span_sect};
  assign first_addr = {start_sect, {SECT_LOG2{1'b0}}};
  assign last_addr  = end_sect[SECT_W] ? {ADDR_W{1'b1}}
                                       : {end_sect[SECT_W-1:0], {SECT_LOG2{1'b1}}};

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    last_d  = last_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (kick) begin
          state_d = SQ_ISSUE;
          addr_d  = first_addr;
          last_d  = last_addr;
        end
      end
      SQ_ISSUE: begin
        if (addr_q == last_q) begin
          state_d = SQ_DRAIN;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      SQ_DRAIN: state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      last_q  <= '0;
      take_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      last_q  <= last_d;
      take_q  <= (state_q == SQ_ISSUE);
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd_en = (state_q == SQ_ISSUE);
  assign take      = take_q;
  assign busy      = (state_q != SQ_IDLE);
endmodule

// File: rtl/crc_scan_engine.sv
module crc_scan_engine
  import crc_scan_pkg::*;
#(
  parameter logic [15:0] POLY   = POLY_DEF,
  parameter logic [15:0] PRESET = PRESET_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d, stepped;

  function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  assign stepped = fold_byte(crc_q, data);

  always_comb begin
    crc_d = crc_q;
    if (clear)     crc_d = PRESET;
    else if (take) crc_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= PRESET;
    else if (clear || take)  crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/crc_range_scanner.sv
module crc_range_scanner
  import crc_scan_pkg::*;
#(
  parameter int          SECT_W    = SECT_W_DEF,
  parameter int          SECT_LOG2 = SECT_LOG2_DEF,
  parameter logic [15:0] POLY      = POLY_DEF,
  parameter logic [15:0] PRESET    = PRESET_DEF,
  localparam int         ADDR_W    = SECT_W + SECT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       crc_out,
  output logic              cpu_stall,
  output logic              scan_done
);
  logic              busy, kick, take;
  logic [SECT_W-1:0] start_sect, span_sect;

  crc_scan_regs #(.SECT_W(SECT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .crc_val(crc_out), .rdata(reg_rdata),
    .start_sect(start_sect), .span_sect(span_sect), .kick(kick)
  );

  crc_scan_seq #(.SECT_W(SECT_W), .SECT_LOG2(SECT_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .start_sect(start_sect),
    .span_sect(span_sect), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .take(take), .busy(busy)
  );

  crc_scan_engine #(.POLY(POLY), .PRESET(PRESET)) u_eng (
    .clk(clk), .rst_n(rst_n), .clear(kick), .take(take),
    .data(mem_rdata), .crc(crc_out)
  );

  assign cpu_stall = busy;
  assign scan_done = !busy;
endmodule

// File: rtl/crc_scan_checker.sv
module crc_scan_checker #(
  parameter int SECT_LOG2 = 10,
  parameter int ADDR_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cpu_stall,
  input logic [15:0]       crc_out
);
  // R4: a scan opens on a sector boundary with a request
  p_first_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> (mem_rd_en && mem_addr[SECT_LOG2-1:0] == '0));

  // R4: addresses step by one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R6: no wrap to zero inside a scan
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr != '0));

  // R5: the issue phase ends on a sector's last byte
  p_end_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_en) |-> ($past(mem_addr[SECT_LOG2-1:0]) == {SECT_LOG2{1'b1}}));

  // R7: one drain cycle after the last request, then release
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_en) |-> (cpu_stall ##1 !cpu_stall));

  // R10: CRC is quiet while idle
  p_crc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stall && $past(!cpu_stall) && !$past(mem_rd_en)) |-> $stable(crc_out));
endmodule

bind crc_range_scanner crc_scan_checker #(.SECT_LOG2(SECT_LOG2), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .cpu_stall(cpu_stall), .crc_out(crc_out)
);

// File: tb/crc_range_scanner_test.sv
module crc_range_scanner_test;
  logic        clk, rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] crc_out;
  logic        cpu_stall, scan_done;

  int errors = 0;
  int checks = 0;

  crc_range_scanner uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .crc_out(crc_out),
    .cpu_stall(cpu_stall), .scan_done(scan_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_byte(mem_addr);
  end

  function automatic logic [15:0] ref_crc(input int first, input int last);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'hFFFF;
    for (int a = first; a <= last; a++) begin
      b = mem_byte(a[15:0]);
      for (int k = 7; k >= 0; k--) begin
        logic fb;
        fb = c[15] ^ b[k];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_scan(input int start, input int cnt, input bit poke);
    int first, last, endsec, nbytes, stalls;
    logic [15:0] exp_addr;
    bit addr_ok;
    logic [7:0] v;
    logic [15:0] got;
    first  = start * 1024;
    endsec = start + cnt;
    last   = (endsec > 63) ? 65535 : (endsec + 1) * 1024 - 1;
    nbytes = last - first + 1;
    wr(2'd0, 8'h80 | start[7:0]);
    wr(2'd1, cnt[7:0]);
    wr(2'd2, 8'h00);
    stalls = 0; exp_addr = first[15:0]; addr_ok = 1'b1;
    // R7: stall must already be up one cycle after the trigger
    check(cpu_stall === 1'b1 && scan_done === 1'b0, "R7 stall start", cpu_stall, 1);
    while (cpu_stall === 1'b1 && stalls < 70000) begin
      stalls++;
      if (mem_rd_en) begin
        if (mem_addr !== exp_addr) addr_ok = 1'b0;
        exp_addr = exp_addr + 16'd1;
      end
      if (poke) begin
        if (stalls == 5) begin reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; end
        if (stalls == 6) begin reg_addr = 2'd1; reg_wdata = 8'h3F; end
        if (stalls == 7) begin reg_addr = 2'd2; end
        if (stalls == 8) reg_wr_en = 1'b0;
      end
      @(negedge clk);
    end
    check(addr_ok, "R4/R5/R6 address sequence", first, first);
    check(exp_addr == 16'((last + 1) & 16'hFFFF), "R5/R6 last address", exp_addr, (last + 1) & 16'hFFFF);
    check(stalls == nbytes + 1, "R7 stall length", stalls, nbytes + 1);
    check(scan_done === 1'b1, "R7 done after scan", scan_done, 1);
    check(crc_out === ref_crc(first, last), "R8 crc_out", crc_out, ref_crc(first, last));
    rd(2'd2, v); got[7:0] = v;
    rd(2'd3, v); got[15:8] = v;
    check(got === ref_crc(first, last), "R8 crc registers", got, ref_crc(first, last));
    rd(2'd0, v);
    check(v === (8'hC0 | start[7:0]), "R9 mode unchanged, R7 done bit", v, 8'hC0 | start[7:0]);
    rd(2'd1, v);
    check(v === cnt[7:0], "R9 span unchanged", v, cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] hold;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); check(v === 8'h40, "R1 mode reset", v, 8'h40);
    rd(2'd1, v); check(v === 8'h00, "R1 span reset", v, 8'h00);
    check(scan_done === 1'b1, "R1 done reset", scan_done, 1);
    check(cpu_stall === 1'b0, "R1 stall reset", cpu_stall, 0);

    wr(2'd1, 8'hFF);
    rd(2'd1, v); check(v === 8'h3F, "R2 span upper bits read 0", v, 8'h3F);
    wr(2'd0, 8'h15);
    rd(2'd0, v); check(v === 8'h55, "R2 mode readback", v, 8'h55);

    // R3: enable off, trigger ignored
    hold = crc_out;
    wr(2'd2, 8'h00);
    check(cpu_stall === 1'b0 && mem_rd_en === 1'b0, "R3 no start when disabled", cpu_stall, 0);
    repeat (5) @(negedge clk);
    check(crc_out === hold && cpu_stall === 1'b0, "R3/R10 crc held", crc_out, hold);

    run_scan(0, 0, 1'b0);
    run_scan(10, 2, 1'b1);
    run_scan(62, 5, 1'b0);   // R6 truncated scan
    run_scan(63, 0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      int s, c;
      s = $urandom % 64;
      c = $urandom % 3;
      run_scan(s, c, i[0]);
    end

    hold = crc_out;
    repeat (8) @(negedge clk);
    check(crc_out === hold, "R10 crc held idle", crc_out, hold);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule